// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Register Bank

This block is instantiated once for each processor core. It collects interrupt requests that other cores send to it, records each request type as its own pending bit, and drives one level interrupt line into the local core while an enabled request is pending. Software on the local core reads the pending bits, handles every request type that is flagged, and then drops exactly those bits by writing the value it read to a clear register. A sender fabric can also raise bits directly through a dedicated set port.

A small four-word mailbox of 64-bit words sits next to the interrupt registers. A booting core writes a start address and its arguments into the mailbox for a parked core. The parked core polls word 0 and treats zero as "not ready". For that reason the writer fills words 3, 2 and 1 first and word 0 last, and after boot word 0 is written back to zero.

The register port is 64 bits wide. The three 32-bit registers take the low half of a write and return zero in the upper half of a read. Reads are combinational from the address. Writes take effect at the clock edge that samples the write strobe.

Top module: `ipi_bank`

## Requirements
- R1: Reset clears the pending bits, the enable register and all four mailbox words, and holds the interrupt output low.
- R2: A read at byte address 0x00 returns the 32 pending bits in the low half of the read data and zero in the upper half. Reading does not change the pending bits.
- R3: A write to byte address 0x08 ORs the low 32 bits of the write data into the pending bits. Bits that were already pending stay pending.
- R4: With the fabric valid input high, the fabric set data is ORed into the pending bits at that clock edge.
- R5: A write to byte address 0x0C clears exactly the pending bits that are set in the low 32 bits of the write data. Writing back a value just read from 0x00 clears all of the bits it reported.
- R6: If a set (from the bus or the fabric) and a clear hit the same bit at the same edge, that bit ends up pending.
- R7: The enable register at byte address 0x04 is written from, and read back in, the low 32 bits. The interrupt output is high exactly while (pending AND enable) is nonzero.
- R8: The mailbox words sit at byte addresses 0x20, 0x28, 0x30 and 0x38 (words 0 to 3). Each is written and read as a full 64-bit value, and writing one word leaves the other three unchanged.
- R9: Reads at 0x08, at 0x0C and at any unmapped address return zero. A write to an unmapped address changes no register.
- R10: A write to byte address 0x00 is ignored. The pending bits change only through a set or a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte address within this core's register region |
| busWrData | input | 64 | Write data |
| busWrEn | input | 1 | Write strobe, sampled at the rising edge |
| busRdData | output | 64 | Read data for busAddr, combinational |
| fabSetValid | input | 1 | Fabric set request valid |
| fabSetData | input | 32 | Mask of bits to raise |
| irqOut | output | 1 | Level interrupt to the local core |

## Verification
A write, or a fabric set, changes the registers at the rising edge that samples it. Both the read data and the interrupt line therefore show the new value in the cycle that follows that edge, with no further register in the path. Read data depends only on the address, so it is valid in the same cycle the address is applied. The bench changes every input at a falling edge. A read is queued in the scoreboard when its address is driven, and the monitor compares it two nanoseconds after the next rising edge. The interrupt line is checked after the falling edge that follows the write, so each result is sampled in the cycle in which it becomes due.

// File: rtl/ipi_bank_pkg.sv
package ipi_bank_pkg;
  localparam int REG_W    = 32;
  localparam int DATA_W   = 64;
  localparam int ADDR_W   = 8;
  localparam int MB_WORDS = 4;
  localparam int MB_IDX_W = $clog2(MB_WORDS);

  localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_ENABLE = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_SET    = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_CLEAR  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_MBOX   = 8'h20;
  localparam int               MB_STRIDE  = 8;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ENABLE,
    SEL_MBOX
  } rdSel_e;

  typedef struct packed {
    logic                enWr;
    logic                setWr;
    logic                clrWr;
    logic [MB_WORDS-1:0] mbWr;
    rdSel_e              rdSel;
    logic [MB_IDX_W-1:0] mbIdx;
  } strobes_t;
endpackage

// File: rtl/ipi_bank_ctrl.sv
module ipi_bank_ctrl
  import ipi_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output strobes_t          strb
);
  always_comb begin
    strb       = '0;
    strb.rdSel = SEL_NONE;
    strb.enWr  = busWrEn && (busAddr == OFF_ENABLE);
    strb.setWr = busWrEn && (busAddr == OFF_SET);
    strb.clrWr = busWrEn && (busAddr == OFF_CLEAR);
    if (busAddr == OFF_STATUS) strb.rdSel = SEL_STATUS;
    if (busAddr == OFF_ENABLE) strb.rdSel = SEL_ENABLE;
    for (int k = 0; k < MB_WORDS; k++) begin
      if (busAddr == ADDR_W'(int'(OFF_MBOX) + k * MB_STRIDE)) begin
        strb.rdSel   = SEL_MBOX;
        strb.mbIdx   = MB_IDX_W'(k);
        strb.mbWr[k] = busWrEn;
      end
    end
  end

  // R9 / R10: a bus write reaches at most one register
  a_r9_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.enWr, strb.setWr, strb.clrWr, strb.mbWr}));
endmodule

// File: rtl/ipi_bank_dp.sv
module ipi_bank_dp
  import ipi_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              fabSetValid,
  input  logic [REG_W-1:0]  fabSetData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqOut
);
  logic [REG_W-1:0]  status;
  logic [REG_W-1:0]  enable;
  logic [REG_W-1:0]  setMask;
  logic [REG_W-1:0]  clrMask;
  logic [DATA_W-1:0] mbox [MB_WORDS];

  assign setMask = (strb.setWr ? busWrData[REG_W-1:0] : '0)
                 | (fabSetValid ? fabSetData : '0);
  assign clrMask = strb.clrWr ? busWrData[REG_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= (status & ~clrMask) | setMask;
      if (strb.enWr) enable <= busWrData[REG_W-1:0];
    end
  end

  for (genvar k = 0; k < MB_WORDS; k++) begin : gMbox
    always_ff @(posedge clk) begin
      if (!rstN)              mbox[k] <= '0;
      else if (strb.mbWr[k])  mbox[k] <= busWrData;
    end
    // R8: a mailbox word only changes when it is addressed
    a_r8_mbox_hold: assert property (@(posedge clk) disable iff (!rstN)
      !strb.mbWr[k] |=> $stable(mbox[k]));
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_STATUS: busRdData = {{(DATA_W-REG_W){1'b0}}, status};
      SEL_ENABLE: busRdData = {{(DATA_W-REG_W){1'b0}}, enable};
      SEL_MBOX:   busRdData = mbox[strb.mbIdx];
      default:    busRdData = '0;
    endcase
  end

  assign irqOut = |(status & enable);

  // R3 / R4 / R6: every raised bit is pending after the edge, clear or not
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (setMask != '0) |=> ((status & $past(setMask)) == $past(setMask)));
  // R5: a cleared bit with no concurrent set is gone after the edge
  a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rstN)
    ((clrMask & ~setMask) != '0) |=> ((status & $past(clrMask & ~setMask)) == '0));
  // R10: pending bits never appear without a set
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((status & ~$past(status) & ~$past(setMask)) == '0));
  // R7: the interrupt rises only after a set or an enable write
  a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past((setMask != '0) || strb.enWr));
endmodule

// File: rtl/ipi_bank.sv
module ipi_bank
  import ipi_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWrEn,
  output logic [DATA_W-1:0] busRdData,
  input  logic              fabSetValid,
  input  logic [REG_W-1:0]  fabSetData,
  output logic              irqOut
);
  strobes_t strb;

  ipi_bank_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strb    (strb)
  );

  ipi_bank_dp uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .busWrData   (busWrData),
    .fabSetValid (fabSetValid),
    .fabSetData  (fabSetData),
    .busRdData   (busRdData),
    .irqOut      (irqOut)
  );
endmodule

// File: tb/tb_ipi_bank.sv
`timescale 1ns/1ps
module tb_ipi_bank;
  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  busAddr;
  logic [63:0] busWrData;
  logic        busWrEn;
  logic [63:0] busRdData;
  logic        fabSetValid;
  logic [31:0] fabSetData;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    logic [63:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  always #4 clk = ~clk;

  ipi_bank dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busRdData(busRdData), .fabSetValid(fabSetValid),
    .fabSetData(fabSetData), .irqOut(irqOut)
  );

  // monitor: compare queued reads shortly after the edge following the address
  always @(posedge clk) begin
    #2;
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (busRdData !== it.exp) begin
        errors++;
        $display("FAIL %s: read got %h expected %h", it.tag, busRdData, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [63:0] e, input string tag);
    @(negedge clk);
    busAddr = a; busWrEn = 1'b0;
    sbq.push_back('{exp: e, tag: tag});
    @(posedge clk);
    #3;
  endtask

  task automatic fabSet(input logic [31:0] m);
    @(negedge clk);
    fabSetValid = 1'b1; fabSetData = m;
    @(negedge clk);
    fabSetValid = 1'b0; fabSetData = '0;
  endtask

  task automatic chkIrq(input logic e, input string tag);
    @(negedge clk);
    checks++;
    if (irqOut !== e) begin
      errors++;
      $display("FAIL %s: irqOut got %b expected %b", tag, irqOut, e);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; busAddr = '0; busWrData = '0; busWrEn = 1'b0;
    fabSetValid = 1'b0; fabSetData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chkIrq(1'b0, "R1 irq after reset");
    rd(8'h00, 64'h0, "R1 status after reset");
    rd(8'h04, 64'h0, "R1 enable after reset");
    for (int k = 0; k < 4; k++) rd(8'h20 + 8'(k * 8), 64'h0, "R1 mailbox after reset");

    // R3 bus set, R2 read is non-destructive, R7 gated by enable
    wr(8'h08, 64'hFFFF_FFFF_0000_0005);
    rd(8'h00, 64'h5, "R3 set via bus");
    rd(8'h00, 64'h5, "R2 second read unchanged");
    chkIrq(1'b0, "R7 irq masked by zero enable");
    wr(8'h08, 64'h1);
    rd(8'h00, 64'h5, "R3 already pending bit stays");

    // R7 enable
    wr(8'h04, 64'hABCD_0000_FFFF_FFFF);
    rd(8'h04, 64'h0000_0000_FFFF_FFFF, "R7 enable readback");
    chkIrq(1'b1, "R7 irq with enabled pending");

    // R4 fabric set
    fabSet(32'h0000_0100);
    rd(8'h00, 64'h105, "R4 fabric set ORs in");

    // R5 clear
    wr(8'h0C, 64'h4);
    rd(8'h00, 64'h101, "R5 clear exact mask");
    wr(8'h0C, 64'h101);
    rd(8'h00, 64'h0, "R5 write-back clears all");
    chkIrq(1'b0, "R7 irq drops after clear");

    // R6 set and clear on the same bit in one edge
    @(negedge clk);
    fabSetValid = 1'b1; fabSetData = 32'h8;
    busAddr = 8'h0C; busWrData = 64'h8; busWrEn = 1'b1;
    @(negedge clk);
    fabSetValid = 1'b0; fabSetData = '0; busWrEn = 1'b0;
    rd(8'h00, 64'h8, "R6 set wins over clear");
    wr(8'h0C, 64'h8);

    // R9 write-only and unmapped reads, unmapped write ignored
    rd(8'h08, 64'h0, "R9 set address reads zero");
    rd(8'h0C, 64'h0, "R9 clear address reads zero");
    wr(8'h10, 64'hDEAD_BEEF_DEAD_BEEF);
    rd(8'h10, 64'h0, "R9 unmapped reads zero");
    rd(8'h00, 64'h0, "R9 unmapped write left status");
    rd(8'h04, 64'hFFFF_FFFF, "R9 unmapped write left enable");

    // R10 write to status ignored
    wr(8'h00, 64'hFFFF_FFFF);
    rd(8'h00, 64'h0, "R10 status write ignored");
    chkIrq(1'b0, "R10 irq stays low");

    // R8 mailbox, filled last word first
    wr(8'h38, 64'h3333_0000_0000_0033);
    wr(8'h30, 64'h2222_0000_0000_0022);
    wr(8'h28, 64'h1111_0000_0000_0011);
    wr(8'h20, 64'h8000_0000_0010_0000);
    rd(8'h20, 64'h8000_0000_0010_0000, "R8 mailbox word0");
    rd(8'h28, 64'h1111_0000_0000_0011, "R8 mailbox word1");
    rd(8'h30, 64'h2222_0000_0000_0022, "R8 mailbox word2");
    rd(8'h38, 64'h3333_0000_0000_0033, "R8 mailbox word3");
    wr(8'h20, 64'h0);
    rd(8'h20, 64'h0, "R8 word0 cleared");
    rd(8'h28, 64'h1111_0000_0000_0011, "R8 word1 untouched");

    // R7 partial enable
    wr(8'h04, 64'h2);
    fabSet(32'h1);
    chkIrq(1'b0, "R7 disabled bit no irq");
    wr(8'h08, 64'h2);
    chkIrq(1'b1, "R7 enabled bit raises irq");
    rd(8'h00, 64'h3, "R4 both bits pending");

    // R1 reset mid-run
    doReset();
    chkIrq(1'b0, "R1 irq after second reset");
    rd(8'h00, 64'h0, "R1 status after second reset");
    rd(8'h04, 64'h0, "R1 enable after second reset");
    rd(8'h28, 64'h0, "R1 mailbox after second reset");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule